// File: doc/BRIEF.md
# GPIO Port Configuration Register Block with Commit Protection

This block holds the pad-configuration state of one 8-bit GPIO port: alternate-function select, pull-up enable, pull-down enable, digital enable and, on analog-capable ports, an analog-mode mask. Software reaches it through a plain synchronous register bus. The bus has a word address, 32-bit write data, a write strobe and a read strobe. Read data appears one cycle after the read strobe.

Selected pins, such as debug-port or non-maskable-interrupt pins, are marked as protected by a parameter. Each write to a configuration register is filtered bit by bit through a commit mask, and the commit-mask bits of protected pins start at 0. Before a protected pin can be changed, software must open a key-guarded lock, set the pin's commit bit, and then write the configuration register. The lock closes again after every successful commit-mask write. Protected pins therefore cannot be reconfigured by a single stray store.

Word address map (3-bit index): 0 alternate function, 1 pull-up, 2 pull-down, 3 digital enable, 4 analog mode, 5 lock, 6 commit mask. Address 7 is unmapped.

Top module: `gpio_cfg_guard`

## Requirements
- R1: A write to address 0, 1, 2 or 3 changes only the bits whose commit-mask bit is 1. Bits whose commit-mask bit is 0 keep their previous value. The same rule applies to all four configuration registers.
- R2: A write to the commit mask (address 6) while the lock reads locked leaves the commit mask unchanged.
- R3: Commit-mask bits of unprotected pins always read 1. Only protected bits take the written value, and bits 31:8 of the commit mask read 0.
- R4: Out of reset, protected commit-mask bits are 0 and unprotected bits are 1. This gives 0xF0 when bits 3:0 are protected and 0x7F when only bit 7 is protected.
- R5: Writing 0x4C4F434B to address 5 unlocks the lock, and writing any other value locks it. Address 5 reads 1 while locked and 0 while unlocked, and it reads 1 after reset.
- R6: A commit-mask write made while unlocked returns the lock to locked in the next cycle.
- R7: After reset, the configuration registers hold their per-port parameter values. In the default configuration the protected pins 3:0 have alternate function and digital enable set (0x0F), and pull-up and pull-down are 0.
- R8: The analog-mode register resets to 0. On an analog-capable port it takes the written low 8 bits. On a port without analog capability it reads 0, its output stays 0, and writes to it have no effect.
- R9: rdata is loaded on the clock edge that samples rd_en and holds its value while rd_en is low. Address 7 reads 0.
- R10: Bits 31:8 of every configuration and analog register read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 3 | Register word index |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe, one access per cycle |
| rd_en | input | 1 | Read strobe |
| rdata | output | 32 | Registered read data |
| alt_sel | output | 8 | Alternate-function select per pin |
| pull_up | output | 8 | Pull-up enable per pin |
| pull_dn | output | 8 | Pull-down enable per pin |
| dig_en | output | 8 | Digital enable per pin |
| analog_en | output | 8 | Analog isolation release per pin |

## Verification
The hardest state to reach is a commit mask that mixes opened and closed protected bits, followed by configuration writes whose data disagrees with the old value on both kinds of bit. That case requires a key write, a commit write, and a check that the lock has already closed again. The vector table walks that chain in order: a locked attempt first, then the key, a partial commit with reserved upper bits set, and a second commit attempt that must be rejected. It then writes inverted data to registers whose reset values differ on protected pins. A second instance with only bit 7 protected and no analog capability covers the other reset pattern and the ignored analog writes.

// File: rtl/gpio_cfg_pkg.sv
package gpio_cfg_pkg;

  localparam int unsigned PIN_W  = 8;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 3;

  localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h4C4F_434B;

  typedef enum logic [ADDR_W-1:0] {
    A_ALT    = 3'd0,
    A_PUP    = 3'd1,
    A_PDN    = 3'd2,
    A_DEN    = 3'd3,
    A_ANALOG = 3'd4,
    A_LOCK   = 3'd5,
    A_COMMIT = 3'd6,
    A_NONE   = 3'd7
  } reg_sel_e;

  localparam int unsigned NUM_CFG = 4;

  // New value of a gated register: enabled bits take the write, others keep.
  function automatic logic [PIN_W-1:0] commit_merge(
    input logic [PIN_W-1:0] old_v,
    input logic [PIN_W-1:0] new_v,
    input logic [PIN_W-1:0] enable
  );
    return (old_v & ~enable) | (new_v & enable);
  endfunction

  // Stored commit mask: protected bits from the write, others forced high.
  function automatic logic [PIN_W-1:0] mask_apply(
    input logic [PIN_W-1:0] wr_v,
    input logic [PIN_W-1:0] prot
  );
    return (wr_v & prot) | ~prot;
  endfunction

  function automatic logic [DATA_W-1:0] zext_pin(input logic [PIN_W-1:0] v);
    return {{(DATA_W-PIN_W){1'b0}}, v};
  endfunction

endpackage

// File: rtl/gpio_lock_ctrl.sv
module gpio_lock_ctrl
  import gpio_cfg_pkg::*;
#(
  parameter logic [DATA_W-1:0] KEY = UNLOCK_KEY
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_wr,
  input  logic [DATA_W-1:0] key_val,
  input  logic              commit_done,
  output logic              locked
);

  logic key_match;
  logic open_evt;
  logic close_evt;

  assign key_match = (key_val == KEY);
  assign open_evt  = key_wr && key_match;
  assign close_evt = (key_wr && !key_match) || commit_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          locked <= 1'b1;
    else if (close_evt)  locked <= 1'b1;
    else if (open_evt)   locked <= 1'b0;
  end

  assert_key_opens_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && key_val == KEY && !commit_done) |=> !locked);

  assert_wrong_key_closes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && key_val != KEY) |=> locked);

  assert_relock_after_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    commit_done |=> locked);

endmodule

// File: rtl/gpio_commit_mask.sv
module gpio_commit_mask
  import gpio_cfg_pkg::*;
#(
  parameter logic [PIN_W-1:0] PROT = 8'h0F
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mask_wr,
  input  logic             locked,
  input  logic [PIN_W-1:0] wr_val,
  output logic [PIN_W-1:0] mask,
  output logic             commit_done
);

  logic [PIN_W-1:0] next_mask;

  assign commit_done = mask_wr && !locked;
  assign next_mask   = mask_apply(wr_val, PROT);

  for (genvar i = 0; i < PIN_W; i++) begin : g_bit
    if (PROT[i]) begin : g_prot
      logic bit_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           bit_q <= 1'b0;
        else if (commit_done) bit_q <= next_mask[i];
      end
      assign mask[i] = bit_q;
    end else begin : g_fixed
      assign mask[i] = 1'b1;
    end
  end

  assert_locked_write_dropped_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_wr && locked) |=> $stable(mask));

endmodule

// File: rtl/gpio_cfg_reg.sv
module gpio_cfg_reg
  import gpio_cfg_pkg::*;
#(
  parameter logic [PIN_W-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [PIN_W-1:0] wr_val,
  input  logic [PIN_W-1:0] enable,
  output logic [PIN_W-1:0] q
);

  logic [PIN_W-1:0] merged;
  assign merged = commit_merge(q, wr_val, enable);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= RST_VAL;
    else if (wr) q <= merged;
  end

  assert_gated_bits_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (((q ^ $past(q)) & ~$past(enable)) == '0));

endmodule

// File: rtl/gpio_cfg_guard.sv
module gpio_cfg_guard
  import gpio_cfg_pkg::*;
#(
  parameter logic [PIN_W-1:0] PROT_PINS  = 8'h0F,
  parameter bit               ANALOG_CAP = 1'b1,
  parameter logic [PIN_W-1:0] RST_ALT    = 8'h0F,
  parameter logic [PIN_W-1:0] RST_PUP    = 8'h00,
  parameter logic [PIN_W-1:0] RST_PDN    = 8'h00,
  parameter logic [PIN_W-1:0] RST_DEN    = 8'h0F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rdata,
  output logic [PIN_W-1:0]  alt_sel,
  output logic [PIN_W-1:0]  pull_up,
  output logic [PIN_W-1:0]  pull_dn,
  output logic [PIN_W-1:0]  dig_en,
  output logic [PIN_W-1:0]  analog_en
);

  localparam logic [NUM_CFG*PIN_W-1:0] CFG_RST = {RST_DEN, RST_PDN, RST_PUP, RST_ALT};

  logic             wr_lock_evt;
  logic             wr_commit_evt;
  logic             wr_analog_evt;
  logic             locked;
  logic             commit_done;
  logic [PIN_W-1:0] cmask;
  logic [PIN_W-1:0] cfg_q [NUM_CFG];
  logic [DATA_W-1:0] rd_mux;

  assign wr_lock_evt   = wr_en && (addr == A_LOCK);
  assign wr_commit_evt = wr_en && (addr == A_COMMIT);
  assign wr_analog_evt = wr_en && (addr == A_ANALOG);

  gpio_lock_ctrl #(.KEY(UNLOCK_KEY)) u_lock (
    .clk         (clk),
    .rst_n       (rst_n),
    .key_wr      (wr_lock_evt),
    .key_val     (wdata),
    .commit_done (commit_done),
    .locked      (locked)
  );

  gpio_commit_mask #(.PROT(PROT_PINS)) u_mask (
    .clk         (clk),
    .rst_n       (rst_n),
    .mask_wr     (wr_commit_evt),
    .locked      (locked),
    .wr_val      (wdata[PIN_W-1:0]),
    .mask        (cmask),
    .commit_done (commit_done)
  );

  for (genvar r = 0; r < NUM_CFG; r++) begin : g_cfg
    logic sel_wr;
    assign sel_wr = wr_en && (addr == ADDR_W'(r));
    gpio_cfg_reg #(.RST_VAL(CFG_RST[r*PIN_W +: PIN_W])) u_reg (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (sel_wr),
      .wr_val (wdata[PIN_W-1:0]),
      .enable (cmask),
      .q      (cfg_q[r])
    );
  end

  assign alt_sel = cfg_q[0];
  assign pull_up = cfg_q[1];
  assign pull_dn = cfg_q[2];
  assign dig_en  = cfg_q[3];

  if (ANALOG_CAP) begin : g_analog
    logic [PIN_W-1:0] amode_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             amode_q <= '0;
      else if (wr_analog_evt) amode_q <= wdata[PIN_W-1:0];
    end
    assign analog_en = amode_q;
  end else begin : g_no_analog
    assign analog_en = '0;
  end

  always_comb begin
    unique case (addr)
      A_ALT, A_PUP, A_PDN, A_DEN: rd_mux = zext_pin(cfg_q[addr[1:0]]);
      A_ANALOG:                   rd_mux = zext_pin(analog_en);
      A_LOCK:                     rd_mux = {{(DATA_W-1){1'b0}}, locked};
      A_COMMIT:                   rd_mux = zext_pin(cmask);
      default:                    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  assert_rdata_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

  assert_analog_absent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ANALOG_CAP |-> (analog_en == '0));

  assert_commit_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_COMMIT) |=> (rdata[DATA_W-1:PIN_W] == '0));

endmodule

// File: tb/gpio_cfg_guard_test.sv
module gpio_cfg_guard_test;
  import gpio_cfg_pkg::*;

  typedef struct packed {
    logic        rd;
    logic [2:0]  addr;
    logic [31:0] data;
    logic [3:0]  req;
  } vec_t;

  localparam int N = 30;
  localparam logic [31:0] KEY = 32'h4C4F434B;
  localparam vec_t TAB [N] = '{
    '{1'b0, 3'd0, 32'hFFFFFF50, 4'd1},  // R1 alt: old 0F, mask F0
    '{1'b1, 3'd0, 32'h0000005F, 4'd1},  // R1 R10
    '{1'b0, 3'd1, 32'h00000033, 4'd1},
    '{1'b1, 3'd1, 32'h00000030, 4'd1},  // R1 pull-up
    '{1'b0, 3'd6, 32'h0000000F, 4'd2},
    '{1'b1, 3'd6, 32'h000000F0, 4'd2},  // R2 locked commit write dropped
    '{1'b0, 3'd5, 32'h12345678, 4'd5},
    '{1'b1, 3'd5, 32'h00000001, 4'd5},  // R5 wrong key
    '{1'b0, 3'd5, KEY,          4'd5},
    '{1'b1, 3'd5, 32'h00000000, 4'd5},  // R5 unlocked
    '{1'b0, 3'd6, 32'hFFFFFF05, 4'd3},
    '{1'b1, 3'd6, 32'h000000F5, 4'd3},  // R3 partial commit
    '{1'b1, 3'd5, 32'h00000001, 4'd6},  // R6 relocked
    '{1'b0, 3'd6, 32'h0000000F, 4'd2},
    '{1'b1, 3'd6, 32'h000000F5, 4'd2},  // R2 second attempt dropped
    '{1'b0, 3'd3, 32'h00000000, 4'd1},
    '{1'b1, 3'd3, 32'h0000000A, 4'd1},  // R1 dig enable
    '{1'b0, 3'd2, 32'h000000FF, 4'd1},
    '{1'b1, 3'd2, 32'h000000F5, 4'd1},  // R1 pull-down
    '{1'b0, 3'd4, 32'hFFFFFF3C, 4'd8},
    '{1'b1, 3'd4, 32'h0000003C, 4'd8},  // R8 analog
    '{1'b0, 3'd7, 32'hFFFFFFFF, 4'd9},
    '{1'b1, 3'd7, 32'h00000000, 4'd9},  // R9 unmapped
    '{1'b0, 3'd5, KEY,          4'd6},
    '{1'b0, 3'd6, 32'h00000000, 4'd6},
    '{1'b1, 3'd6, 32'h000000F0, 4'd6},  // R6 close protected again
    '{1'b1, 3'd5, 32'h00000001, 4'd6},
    '{1'b0, 3'd0, 32'h00000000, 4'd1},
    '{1'b1, 3'd0, 32'h0000000F, 4'd1},  // R1 protected alt bits kept
    '{1'b1, 3'd1, 32'h00000030, 4'd9}   // R9 reread
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr = '0, b_addr = '0;
  logic [31:0] wdata = '0, b_wdata = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0, b_wr_en = 1'b0, b_rd_en = 1'b0;
  logic [31:0] rdata, b_rdata;
  logic [7:0]  alt_sel, pull_up, pull_dn, dig_en, analog_en;
  logic [7:0]  b_alt, b_pup, b_pdn, b_den, b_analog;
  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;  // 50 MHz

  gpio_cfg_guard uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .rdata(rdata), .alt_sel(alt_sel), .pull_up(pull_up),
    .pull_dn(pull_dn), .dig_en(dig_en), .analog_en(analog_en)
  );

  gpio_cfg_guard #(
    .PROT_PINS(8'h80), .ANALOG_CAP(1'b0), .RST_ALT(8'h80),
    .RST_PUP(8'h00), .RST_PDN(8'h00), .RST_DEN(8'h80)
  ) uut_b (
    .clk(clk), .rst_n(rst_n), .addr(b_addr), .wdata(b_wdata), .wr_en(b_wr_en),
    .rd_en(b_rd_en), .rdata(b_rdata), .alt_sel(b_alt), .pull_up(b_pup),
    .pull_dn(b_pdn), .dig_en(b_den), .analog_en(b_analog)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input bit b, input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    if (b) begin b_addr = a; b_wdata = d; b_wr_en = 1'b1; end
    else   begin addr = a;   wdata = d;   wr_en = 1'b1;   end
    @(negedge clk);
    wr_en = 1'b0; b_wr_en = 1'b0;
  endtask

  task automatic rd(input bit b, input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    if (b) begin b_addr = a; b_rd_en = 1'b1; end
    else   begin addr = a;   rd_en = 1'b1;   end
    @(negedge clk);
    rd_en = 1'b0; b_rd_en = 1'b0;
    d = b ? b_rdata : rdata;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset state
    check("R7 alt reset", {24'h0, alt_sel}, 32'h0F);
    check("R7 den reset", {24'h0, dig_en}, 32'h0F);
    check("R7 pull reset", {16'h0, pull_up, pull_dn}, 32'h0);
    check("R8 analog reset", {24'h0, analog_en}, 32'h0);
    check("R9 rdata reset", rdata, 32'h0);
    rd(1'b0, 3'd6, v); check("R4 commit reset", v, 32'hF0);
    rd(1'b0, 3'd5, v); check("R5 lock reset", v, 32'h1);

    // Vector table
    for (int i = 0; i < N; i++) begin
      if (TAB[i].rd) begin
        rd(1'b0, TAB[i].addr, v);
        check($sformatf("R%0d vec%0d", TAB[i].req, i), v, TAB[i].data);
      end else begin
        wr(1'b0, TAB[i].addr, TAB[i].data);
      end
    end

    // Output ports after the table
    check("R1 alt_sel port", {24'h0, alt_sel}, 32'h0F);
    check("R1 pull_dn port", {24'h0, pull_dn}, 32'hF5);
    check("R1 dig_en port", {24'h0, dig_en}, 32'h0A);
    check("R8 analog_en port", {24'h0, analog_en}, 32'h3C);

    // R9: latency and hold
    @(negedge clk); addr = 3'd2; rd_en = 1'b1;
    check("R9 before edge", rdata, 32'h30);
    @(negedge clk); rd_en = 1'b0; addr = 3'd5;
    check("R9 after edge", rdata, 32'hF5);
    @(negedge clk);
    check("R9 hold", rdata, 32'hF5);

    // Second port: bit 7 protected, no analog
    check("R7 b alt reset", {24'h0, b_alt}, 32'h80);
    rd(1'b1, 3'd6, v); check("R4 b commit reset", v, 32'h7F);
    wr(1'b1, 3'd4, 32'hFF);
    check("R8 b analog port", {24'h0, b_analog}, 32'h0);
    rd(1'b1, 3'd4, v); check("R8 b analog read", v, 32'h0);
    wr(1'b1, 3'd0, 32'h00);
    check("R1 b alt keeps bit7", {24'h0, b_alt}, 32'h80);
    wr(1'b1, 3'd5, KEY);
    wr(1'b1, 3'd6, 32'h80);
    rd(1'b1, 3'd6, v); check("R3 b commit opened", v, 32'hFF);
    wr(1'b1, 3'd0, 32'h00);
    check("R1 b alt cleared", {24'h0, b_alt}, 32'h00);
    rd(1'b1, 3'd5, v); check("R6 b relocked", v, 32'h1);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule